// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on separate clocks, which may be unrelated or the same. The number of entries is a power-of-two parameter that defaults to 256. Each side keeps its own binary pointer. Each pointer crosses into the other domain as Gray code through a two-stage synchronizer. Full and almost-full are registered in the write domain, and empty and almost-empty are registered in the read domain. All four flags are active low.

A configuration pin (`wen2_ld`) is captured on every clock edge while the active-low reset is held.
- If the pin is high, the block runs in two-enable mode. The pin is a second, active-high write enable, so that several buffers can be cascaded for depth expansion. The almost thresholds use a fixed default.
- If the pin is low, the block runs in programmable-flag mode. The almost thresholds come from two 16-bit offsets, each supplied as a high byte and a low byte by an external offset store. In this mode, a low level on the same pin means an offset-load cycle, so no normal write happens.

Reads need both active-low read enables. The data output is a register that changes only on an accepted read.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after it rises, `full_n`=1, `af_n`=1, `empty_n`=0, `ae_n`=0 and `dout`=0.
- R2: The level of `wen2_ld` while `rst_n` is low sets the mode: 1 selects two-enable mode and 0 selects programmable-flag mode. Changes to `wen2_ld` after reset do not change the mode.
- R3: In either mode, a word is stored on a rising `wclk` only when `wen1_n`=0 and `wen2_ld`=1. Any other combination stores nothing.
- R4: `dout` loads the oldest stored word on a rising `rclk` only when `ren1_n`=0 and `ren2_n`=0. Otherwise `dout` keeps its value.
- R5: When DEPTH words are held, `full_n` is low once the flags have settled. Write attempts while `full_n` is low store nothing.
- R6: When no words are held, `empty_n` is low once the flags have settled. Read attempts while `empty_n` is low leave `dout` unchanged.
- R7: In programmable-flag mode, `ae_n` is low exactly when the held count is at most the empty offset. The empty offset is `{ae_off_hi, ae_off_lo}` truncated to its low log2(DEPTH)+1 bits.
- R8: In programmable-flag mode, `af_n` is low exactly when DEPTH minus the held count is at most the full offset. The full offset is `{af_off_hi, af_off_lo}` truncated to its low log2(DEPTH)+1 bits.
- R9: In two-enable mode, the offset inputs are ignored and both almost thresholds equal the parameter DEF_OFF.
- R10: Words leave in the order they were accepted, with no loss or duplication, while both clocks run concurrently at unrelated rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| din | input | DW | Write data |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Mode select during reset; afterwards a second write enable (two-enable mode) or the load/normal select (programmable-flag mode) |
| ren1_n | input | 1 | First active-low read enable |
| ren2_n | input | 1 | Second active-low read enable |
| ae_off_lo | input | 8 | Empty offset, low byte |
| ae_off_hi | input | 8 | Empty offset, high byte |
| af_off_lo | input | 8 | Full offset, low byte |
| af_off_hi | input | 8 | Full offset, high byte |
| dout | output | DW | Registered read data |
| full_n | output | 1 | Full flag, active low, write domain |
| af_n | output | 1 | Almost-full flag, active low, write domain |
| empty_n | output | 1 | Empty flag, active low, read domain |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The hardest situations to reach from the ports are the full boundary, where a write must be refused, and the threshold edges of both almost flags. The flags only settle after a pointer has crossed domains, which makes these edges awkward to hit.

The bench uses a 16-entry configuration and moves the fill level one word at a time through every value from 0 to 16 and back. It waits for the synchronizers to settle at each level and compares all four flags with thresholds computed arithmetically. It does this once per mode, with offsets whose high bytes are nonzero so that truncation matters.

A separate phase streams words with irregular gaps under unrelated clock periods. It checks the order of the data, and whether each refused write or read really left the buffer untouched.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {
    CFG_PFLAG  = 1'b0,
    CFG_TWO_WE = 1'b1
  } cfg_mode_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int N = 1 << AW;
  logic [DW-1:0] mem [N];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[raddr];
  end

  // R4: the output register moves only on an accepted read
  p_q_hold_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    !re |=> $stable(q));
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          cfg_pin,
  input  logic          wen1_n,
  input  logic          wen2,
  input  logic [7:0]    off_lo,
  input  logic [7:0]    off_hi,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          af_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  cfg_mode_e     mode_q;
  logic [PW-1:0] wbin, wbin_nx, rbin_s, used_nx, free_nx, thr;
  logic          wr_go;

  always_ff @(posedge wclk) begin
    if (!rst_n) mode_q <= cfg_mode_e'(cfg_pin);
  end

  assign thr     = (mode_q == CFG_PFLAG) ? PW'({off_hi, off_lo}) : PW'(DEF_OFF);
  assign wr_go   = !wen1_n && wen2 && full_n;
  assign wbin_nx = wbin + PW'(wr_go);
  assign rbin_s  = PW'(from_gray(32'(rgray_s)));
  assign used_nx = wbin_nx - rbin_s;
  assign free_nx = PW'(DEPTH) - used_nx;

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
      af_n   <= 1'b1;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= PW'(to_gray(32'(wbin_nx)));
      full_n <= (used_nx != PW'(DEPTH));
      af_n   <= !(free_nx <= thr);
    end
  end

  assign we    = wr_go;
  assign waddr = wbin[AW-1:0];

  p_full_blocks_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wgray));
  p_no_overfill_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    (wbin - rbin_s) <= PW'(DEPTH));
  p_full_implies_af_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !af_n);
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DEF_OFF = 7
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          cfg_pin,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [7:0]    off_lo,
  input  logic [7:0]    off_hi,
  input  logic [AW:0]   wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty_n,
  output logic          ae_n
);
  localparam int PW = AW + 1;

  cfg_mode_e     mode_q;
  logic [PW-1:0] rbin, rbin_nx, wbin_s, used_nx, thr;
  logic          rd_go;

  always_ff @(posedge rclk) begin
    if (!rst_n) mode_q <= cfg_mode_e'(cfg_pin);
  end

  assign thr     = (mode_q == CFG_PFLAG) ? PW'({off_hi, off_lo}) : PW'(DEF_OFF);
  assign rd_go   = !ren1_n && !ren2_n && empty_n;
  assign rbin_nx = rbin + PW'(rd_go);
  assign wbin_s  = PW'(from_gray(32'(wgray_s)));
  assign used_nx = wbin_s - rbin_nx;

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= PW'(to_gray(32'(rbin_nx)));
      empty_n <= (used_nx != '0);
      ae_n    <= !(used_nx <= thr);
    end
  end

  assign re    = rd_go;
  assign raddr = rbin[AW-1:0];

  p_empty_blocks_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rgray));
  p_empty_implies_ae_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !ae_n);
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag #(
  parameter int DW          = 9,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_OFF     = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [7:0]    ae_off_lo,
  input  logic [7:0]    ae_off_hi,
  input  logic [7:0]    af_off_lo,
  input  logic [7:0]    af_off_hi,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          af_n,
  output logic          empty_n,
  output logic          ae_n
);
  localparam int AW = $clog2(DEPTH);

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

  dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_wr_ctl #(.AW(AW), .DEF_OFF(DEF_OFF)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .cfg_pin(wen2_ld),
    .wen1_n(wen1_n), .wen2(wen2_ld),
    .off_lo(af_off_lo), .off_hi(af_off_hi), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .full_n(full_n), .af_n(af_n));

  dcf_rd_ctl #(.AW(AW), .DEF_OFF(DEF_OFF)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .cfg_pin(wen2_ld),
    .ren1_n(ren1_n), .ren2_n(ren2_n),
    .off_lo(ae_off_lo), .off_hi(ae_off_hi), .wgray_s(wgray_s),
    .re(re), .raddr(raddr), .rgray(rgray), .empty_n(empty_n), .ae_n(ae_n));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .rclk(rclk), .rst_n(rst_n), .re(re), .raddr(raddr), .q(dout));

  // R4: with either read enable high, data output holds
  p_ren_hold_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n || ren2_n) |=> $stable(dout));
endmodule

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/1ps
module sim_dcfifo_pflag;
  localparam int DW = 9, DEPTH = 16, DEF = 5, MASK = 2*DEPTH - 1;

  logic wclk = 0, rclk = 0;
  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  logic rst_n = 0, wen1_n = 1, wen2_ld = 0, ren1_n = 1, ren2_n = 1;
  logic [DW-1:0] din = '0, dout;
  logic [7:0] ae_lo = 0, ae_hi = 0, af_lo = 0, af_hi = 0;
  logic full_n, af_n, empty_n, ae_n;

  dcfifo_pflag #(.DW(DW), .DEPTH(DEPTH), .DEF_OFF(DEF)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .ae_off_lo(ae_lo), .ae_off_hi(ae_hi), .af_off_lo(af_lo), .af_off_hi(af_hi),
    .dout(dout), .full_n(full_n), .af_n(af_n), .empty_n(empty_n), .ae_n(ae_n));

  int n_chk = 0, n_bad = 0, pushed = 0, popped = 0;
  bit prog = 1, done = 0;
  logic [DW-1:0] mq [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit two_we, input logic [15:0] aeo, input logic [15:0] afo);
    @(negedge wclk);
    rst_n = 0; wen2_ld = two_we; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    {ae_hi, ae_lo} = aeo; {af_hi, af_lo} = afo;
    mq.delete(); prog = !two_we;
    repeat (6) @(posedge rclk);
    @(negedge wclk);
    chk(full_n == 1 && af_n == 1 && empty_n == 0 && ae_n == 0 && dout == 0,
        "R1", "reset flags/dout", {full_n, af_n, empty_n, ae_n}, 4'b1100);
    rst_n = 1;
    repeat (3) @(negedge wclk);
    wen2_ld = 1;
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic check_flags(input string req);
    int c, eo, fo;
    c  = mq.size();
    eo = prog ? int'({ae_hi, ae_lo} & MASK) : DEF;
    fo = prog ? int'({af_hi, af_lo} & MASK) : DEF;
    chk(empty_n == (c != 0), "R6", "empty_n", empty_n, c != 0);
    chk(full_n == (c != DEPTH), "R5", "full_n", full_n, c != DEPTH);
    chk(ae_n == !(c <= eo), req, "ae_n", ae_n, !(c <= eo));
    chk(af_n == !((DEPTH - c) <= fo), req, "af_n", af_n, !((DEPTH - c) <= fo));
  endtask

  task automatic push(input logic [DW-1:0] d, input logic w1, input logic w2);
    bit ok;
    @(negedge wclk);
    ok = full_n && !w1 && w2;
    din = d; wen1_n = w1; wen2_ld = w2;
    @(posedge wclk);
    if (ok) begin mq.push_back(d); pushed++; end
    @(negedge wclk);
    wen1_n = 1; wen2_ld = 1;
  endtask

  task automatic pop(input logic r1, input logic r2, input string req);
    bit ok;
    logic [DW-1:0] prev, exp;
    @(negedge rclk);
    ok = empty_n && !r1 && !r2;
    prev = dout; ren1_n = r1; ren2_n = r2;
    @(posedge rclk);
    @(negedge rclk);
    ren1_n = 1; ren2_n = 1;
    if (ok) begin
      exp = mq.pop_front(); popped++;
      chk(dout == exp, "R10", "read data order", dout, exp);
    end else begin
      chk(dout == prev, req, "dout held", dout, prev);
    end
  endtask

  task automatic sweep(input string req, input int seed);
    check_flags(req);
    for (int i = 0; i < DEPTH; i++) begin
      push(DW'(seed + i * 13), 0, 1);
      settle();
      check_flags(req);
    end
    push(9'h1AA, 0, 1);           // R5: refused at full
    settle();
    check_flags("R5");
    for (int i = 0; i < DEPTH; i++) begin
      pop(0, 0, "R4");
      settle();
      check_flags(req);
    end
    pop(0, 0, "R6");               // R6: read at empty keeps dout
    settle();
    check_flags("R6");
  endtask

  initial begin
    // Programmable-flag mode; high bytes nonzero to exercise truncation (R7, R8)
    do_reset(0, 16'hA003, 16'h4022);
    push(9'h055, 0, 0);            // R3: load-cycle level, no store
    push(9'h066, 1, 1);            // R3: wen1_n high, no store
    settle();
    chk(empty_n == 0, "R3", "refused writes leave empty", empty_n, 0);
    sweep("R7", 3);
    // R4: only one read enable low
    push(9'h111, 0, 1);
    push(9'h122, 0, 1);
    settle();
    pop(0, 1, "R4");
    pop(1, 0, "R4");
    settle();
    check_flags("R8");
    pop(0, 0, "R4");
    pop(0, 0, "R4");
    settle();
    check_flags("R2");             // R2: post-reset wen2_ld changes kept offsets in use

    // Two-enable mode: offsets must be ignored (R9)
    do_reset(1, 16'h0000, 16'h0001);
    push(9'h077, 0, 0);            // R3: second enable low
    settle();
    chk(empty_n == 0, "R3", "second enable low blocks", empty_n, 0);
    sweep("R9", 40);

    // Concurrent streaming, unrelated clocks (R10)
    do_reset(0, 16'h0005, 16'h0004);
    pushed = 0; popped = 0;
    fork
      begin
        int k = 0;
        while (pushed < 150) begin
          push(DW'(k * 7 + 1), 0, 1);
          if (mq.size() > 0 && mq[mq.size()-1] == DW'(k * 7 + 1)) k++;
          if ($urandom % 4 == 0) @(negedge wclk);
        end
      end
      begin
        while (popped < 150) begin
          pop(0, 0, "R6");
          if ($urandom % 3 == 0) repeat (2) @(negedge rclk);
        end
      end
    join
    settle();
    check_flags("R10");
    chk(popped == 150, "R10", "words delivered", popped, 150);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule